// File: doc/BRIEF.md
# Dual-Counter PWM Timer

This peripheral holds two counters of equal, parameterised width. Each counter has a load value, a running count and a control word. Software reaches them through a small memory-mapped port where every read and write completes in one cycle. Each counter can count either up or down. It can copy its load value into the count on command. When it reaches its terminal value it can reload itself and go on, or it can stop. Each counter drives its own single-clock generate pulse.

When both control words select the pulse-width configuration, the two counters work together and drive one active-high output. Counter 0 sets the period and counter 1 sets the high time. The output goes high when counter 0 reloads, at which point counter 1 is restarted. The output goes low when counter 1 reaches its terminal value. Each reload costs two clocks, so a counter's cycle is its load value plus two clocks when counting down, and the maximum count minus the load value plus two clocks when counting up. If the high time is not shorter than the period, the output stays low, so a 100% duty cycle cannot be produced.

To start the output, software writes both load values, pulses the load bits, and then writes both control words. The last of these writes carries the enable-all bit, so both counters start on the same clock edge.

Top module: `pwm_dual_timer`

## Requirements
- R1: After a synchronous reset, every control, load and count register reads zero, and the generate pulses and the PWM output are low.
- R2: Registers use a 4-byte stride. Counter 0 is at 0x00 (control), 0x04 (load) and 0x08 (count); counter 1 is at 0x10, 0x14 and 0x18. The control bits are: bit0 count down, bit1 capture mode, bit2 generate-out enable, bit3 auto-reload, bit4 load, bit5 run, bit6 PWM enable, bit7 cascade, bit8 enable-all. Control words read back bits 7:0, and bit8 reads as zero. Writes to a count register are ignored.
- R3: While the load bit is set, the count register takes the load value on every clock, and no counting happens even if the run bit is set.
- R4: A running down-counting counter with auto-reload produces one generate pulse every load+2 clocks. Each pulse lasts exactly one clock.
- R5: A running up-counting counter with auto-reload produces one generate pulse every max−load+2 clocks, where max = 2^width − 1.
- R6: Without auto-reload, a counter gives a single generate pulse at its terminal value, then clears its own run bit and holds its count there.
- R7: Writing a control word with bit8 set sets the run bit of both counters on the same clock edge, so the two counters stay in step.
- R8: The PWM output is low unless all of the following hold: both counters have PWM enable, generate-out enable, auto-reload and run set; both have load and capture clear; and counter 0 has cascade clear. The output is low from the clock after any of these stops holding.
- R9: With PWM active, the output repeats with a period equal to counter 0's cycle length and stays high for counter 1's cycle length in each period, in both count directions.
- R10: When counter 1's cycle length is equal to or longer than counter 0's, the PWM output stays low.
- R11: A load value written while the counters run leaves the period in progress unchanged. It takes effect from the next reload.
- R12: A generate pulse appears on a counter's output only when that counter has generate-out enable set and capture mode clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address, must be word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| gen0_out | output | 1 | Generate pulse of counter 0 |
| gen1_out | output | 1 | Generate pulse of counter 1 |
| pwm_out | output | 1 | Active-high PWM output |

## Verification
The assertions check the following on every cycle:
- a held load bit forces the count to the load value;
- a running counter that is not at its terminal value steps by exactly one;
- generate pulses never last two clocks;
- a no-reload counter drops its run bit after its pulse;
- enable-all starts both counters;
- the output falls whenever the PWM conditions stop holding, and rises only on a period pulse with a high time shorter than the period.

The actual cycle lengths can only be shown by the bench scenarios. These cover the +2 reload cost in both directions, measured high times and periods across a sweep of period and duty values, the equal and longer duty cases, and the one-period delay before a load value written mid-run takes effect.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    // Control word of one counter, bit 0 at the bottom.
    typedef struct packed {
        logic cascade;   // bit7
        logic pwm_en;    // bit6
        logic run;       // bit5
        logic load;      // bit4
        logic reload;    // bit3
        logic gen_en;    // bit2
        logic capture;   // bit1
        logic down;      // bit0
    } ctl_t;

    localparam int CTL_W     = 8;
    localparam int ENALL_BIT = 8;

    localparam logic [1:0] REG_CTL   = 2'd0;
    localparam logic [1:0] REG_LOAD  = 2'd1;
    localparam logic [1:0] REG_COUNT = 2'd2;

    // Clocks per counter cycle, including the two clocks of reload overhead.
    function automatic logic [32:0] cycle_len(input logic [31:0] ld,
                                              input logic [31:0] top,
                                              input logic        dn);
        if (dn) return {1'b0, ld} + 33'd2;
        return {1'b0, top} - {1'b0, ld} + 33'd2;
    endfunction

    // Both control words must select the paired pulse-width configuration.
    function automatic logic pwm_qualified(input ctl_t a, input ctl_t b);
        return a.pwm_en && b.pwm_en && a.gen_en && b.gen_en &&
               a.reload && b.reload && a.run && b.run &&
               !a.load && !b.load && !a.capture && !b.capture && !a.cascade;
    endfunction

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_ctl,
    input  logic         wr_load,
    input  logic [31:0]  wdata,
    input  logic         set_run,
    input  logic         restart,
    output ctl_t         ctl_o,
    output logic [W-1:0] load_o,
    output logic [W-1:0] count_o,
    output logic         tick_o,
    output logic         gen_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    ctl_t         ctl_q, ctl_d;
    logic [W-1:0] load_q, cnt_q;
    logic         pend_q, at_end, stop;

    always_comb at_end = ctl_q.down ? (cnt_q == '0) : (cnt_q == TOP);
    always_comb stop   = pend_q && ctl_q.run && !ctl_q.reload && !ctl_q.load;

    always_comb begin
        ctl_d = ctl_q;
        if (stop)    ctl_d.run = 1'b0;
        if (wr_ctl)  ctl_d = ctl_t'(wdata[CTL_W-1:0]);
        if (set_run) ctl_d.run = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            load_q <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            if (wr_load) load_q <= wdata[W-1:0];
            if (ctl_q.load || restart) begin
                cnt_q  <= load_q;
                pend_q <= 1'b0;
            end else if (ctl_q.run) begin
                if (pend_q) begin
                    pend_q <= 1'b0;
                    if (ctl_q.reload) cnt_q <= load_q;
                end else if (at_end) begin
                    pend_q <= 1'b1;
                end else if (ctl_q.down) begin
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    assign ctl_o   = ctl_q;
    assign load_o  = load_q;
    assign count_o = cnt_q;
    assign tick_o  = pend_q;
    assign gen_o   = pend_q && ctl_q.gen_en && !ctl_q.capture;

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.load |=> (cnt_q == $past(load_q)));

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.run && !ctl_q.load && !restart && !pend_q && !at_end) |=>
        (cnt_q == ($past(ctl_q.down) ? $past(cnt_q) - W'(1) : $past(cnt_q) + W'(1))));

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> !pend_q);

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && ctl_q.run && !ctl_q.reload && !ctl_q.load && !wr_ctl && !set_run)
        |=> !ctl_q.run);

endmodule

// File: rtl/pwmt_shaper.sv
module pwmt_shaper
    import pwmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl0,
    input  ctl_t         ctl1,
    input  logic [W-1:0] load0,
    input  logic [W-1:0] load1,
    input  logic         tick0,
    input  logic         tick1,
    output logic         pwm_o,
    output logic         active_o
);

    localparam logic [31:0] TOP32 = 32'((64'd1 << W) - 64'd1);

    logic [32:0] per_len, hi_len;
    logic        duty_fits, active, pwm_q;

    always_comb begin
        per_len   = cycle_len(32'(load0), TOP32, ctl0.down);
        hi_len    = cycle_len(32'(load1), TOP32, ctl1.down);
        duty_fits = hi_len < per_len;
        active    = pwm_qualified(ctl0, ctl1);
    end

    // Period pulse wins over a coincident duty pulse.
    always_ff @(posedge clk) begin
        if (rst || !active)  pwm_q <= 1'b0;
        else if (tick0)      pwm_q <= duty_fits;
        else if (tick1)      pwm_q <= 1'b0;
    end

    assign pwm_o    = pwm_q;
    assign active_o = active;

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !pwm_q);

    // R9
    duty_end_chk: assert property (@(posedge clk) disable iff (rst)
        (active && tick1 && !tick0) |=> !pwm_q);

    // R9
    rise_on_period_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_q) |-> $past(tick0));

    // R10
    full_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_q) |-> $past(duty_fits));

endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        gen0_out,
    output logic        gen1_out,
    output logic        pwm_out
);

    localparam int NCNT = 2;

    ctl_t             ctl_v  [NCNT];
    logic [CNT_W-1:0] load_v [NCNT];
    logic [CNT_W-1:0] cnt_v  [NCNT];
    logic [NCNT-1:0]  tick_v, gen_v, wr_ctl, wr_load;
    logic             aligned, enall_wr, pwm_active, restart1;
    logic             sel;

    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        sel      = bus_addr[4];
        enall_wr = bus_wr && aligned && (bus_addr[3:2] == REG_CTL) && bus_wdata[ENALL_BIT];
        restart1 = pwm_active && tick_v[0];
    end

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        always_comb begin
            wr_ctl[i]  = bus_wr && aligned && (sel == i[0]) && (bus_addr[3:2] == REG_CTL);
            wr_load[i] = bus_wr && aligned && (sel == i[0]) && (bus_addr[3:2] == REG_LOAD);
        end

        pwmt_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .wr_ctl  (wr_ctl[i]),
            .wr_load (wr_load[i]),
            .wdata   (bus_wdata),
            .set_run (enall_wr),
            .restart ((i == 1) ? restart1 : 1'b0),
            .ctl_o   (ctl_v[i]),
            .load_o  (load_v[i]),
            .count_o (cnt_v[i]),
            .tick_o  (tick_v[i]),
            .gen_o   (gen_v[i])
        );
    end

    pwmt_shaper #(.W(CNT_W)) u_shaper (
        .clk      (clk),
        .rst      (rst),
        .ctl0     (ctl_v[0]),
        .ctl1     (ctl_v[1]),
        .load0    (load_v[0]),
        .load1    (load_v[1]),
        .tick0    (tick_v[0]),
        .tick1    (tick_v[1]),
        .pwm_o    (pwm_out),
        .active_o (pwm_active)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (bus_addr[3:2])
                REG_CTL:   bus_rdata = 32'(ctl_v[sel]);
                REG_LOAD:  bus_rdata = 32'(load_v[sel]);
                REG_COUNT: bus_rdata = 32'(cnt_v[sel]);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign gen0_out = gen_v[0];
    assign gen1_out = gen_v[1];

    // R7
    enall_both_chk: assert property (@(posedge clk) disable iff (rst)
        enall_wr |=> (ctl_v[0].run && ctl_v[1].run));

endmodule

// File: tb/test_pwm_dual_timer.sv
module test_pwm_dual_timer;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int TOPV       = 255;

    localparam logic [4:0] CTL0 = 5'h00, LD0 = 5'h04, CNT0 = 5'h08;
    localparam logic [4:0] CTL1 = 5'h10, LD1 = 5'h14, CNT1 = 5'h18;

    localparam logic [31:0] B_DOWN = 32'h001, B_CAPT = 32'h002, B_GEN  = 32'h004;
    localparam logic [31:0] B_RELD = 32'h008, B_LOAD = 32'h010, B_RUN  = 32'h020;
    localparam logic [31:0] B_PWM  = 32'h040, B_CASC = 32'h080, B_ALL  = 32'h100;
    localparam logic [31:0] CFG    = B_GEN | B_RELD | B_PWM;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        gen0_out, gen1_out, pwm_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_dual_timer #(.CNT_W(W)) i_pwm_dual_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gen0_out  (gen0_out),
        .gen1_out  (gen1_out),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic pick(input int s);
        case (s)
            0:       return gen0_out;
            1:       return gen1_out;
            default: return pwm_out;
        endcase
    endfunction

    function automatic int clen(input logic dn, input int ld);
        return dn ? ld + 2 : TOPV - ld + 2;
    endfunction

    // Waits for a rising edge of the selected signal, then measures the high
    // time and the distance to the following rising edge.
    task automatic measure(input int s, output int hi, output int per);
        int   g = 0;
        logic prev;
        hi = 0; per = 0;
        while (pick(s) && g < 3000) begin @(negedge clk); g++; end
        while (!pick(s) && g < 3000) begin @(negedge clk); g++; end
        hi = 1; prev = 1'b1;
        while (g < 3000) begin
            @(negedge clk); g++; per++;
            if (pick(s) && !prev) break;
            if (pick(s)) hi++;
            prev = pick(s);
        end
    endtask

    task automatic count_high(input int s, input int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pick(s)) hits++;
        end
    endtask

    task automatic start_pwm(input logic dn, input int l0, input int l1, input logic [31:0] extra0);
        wr(CTL0, 32'h0); wr(CTL1, 32'h0);
        wr(LD0, 32'(l0)); wr(LD1, 32'(l1));
        wr(CTL0, B_LOAD | 32'(dn)); wr(CTL1, B_LOAD | 32'(dn));
        wr(CTL0, CFG | 32'(dn) | extra0);
        wr(CTL1, CFG | 32'(dn) | B_ALL);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int hi, per, hits, mism;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(CTL0, v); check("R1 ctl0", v, 0);
        rd(LD1, v);  check("R1 load1", v, 0);
        rd(CNT1, v); check("R1 count1", v, 0);
        check("R1 outputs", {gen0_out, gen1_out, pwm_out}, 0);

        // R2 count register read-only, load untouched
        wr(CNT0, 32'h77);
        rd(CNT0, v); check("R2 count write ignored", v, 0);
        rd(LD0, v);  check("R2 load0 untouched", v, 0);
        // R2 control readback, enable-all reads zero
        wr(CTL1, B_ALL | B_CASC | B_RELD | B_CAPT | B_DOWN);
        rd(CTL1, v); check("R2 ctl1 readback", v, 32'hAB);
        rd(CTL0, v); check("R2 ctl0 run by enable-all", v, 32'h20);
        wr(CTL0, 0); wr(CTL1, 0);

        // R3 load command copies and holds
        wr(LD0, 40); wr(CTL0, B_LOAD | B_RUN | B_DOWN);
        repeat (5) @(negedge clk);
        rd(CNT0, v); check("R3 count held at load", v, 40);
        wr(LD0, 41); @(negedge clk);
        rd(CNT0, v); check("R3 count follows load", v, 41);
        wr(CTL0, 0);

        // R4 down count cycle length and pulse width
        wr(LD0, 40); wr(CTL0, B_LOAD | B_DOWN);
        wr(CTL0, B_RUN | B_DOWN | B_RELD | B_GEN);
        measure(0, hi, per);
        check("R4 down interval", per, clen(1'b1, 40));
        check("R4 pulse width", hi, 1);
        wr(CTL0, 0);

        // R5 up count cycle length
        wr(LD0, 240); wr(CTL0, B_LOAD);
        wr(CTL0, B_RUN | B_RELD | B_GEN);
        measure(0, hi, per);
        check("R5 up interval", per, clen(1'b0, 240));

        // R12 gating of the generate pulse
        wr(CTL0, B_RUN | B_RELD);
        count_high(0, 60, hits); check("R12 no gen enable", hits, 0);
        wr(CTL0, B_RUN | B_RELD | B_GEN | B_CAPT);
        count_high(0, 60, hits); check("R12 capture mode", hits, 0);
        wr(CTL0, 0);

        // R6 one-shot without auto-reload
        wr(LD0, 5); wr(CTL0, B_LOAD | B_DOWN | B_GEN);
        wr(CTL0, B_RUN | B_DOWN | B_GEN);
        count_high(0, 40, hits); check("R6 single pulse", hits, 1);
        rd(CTL0, v); check("R6 run cleared", v, 32'h05);
        rd(CNT0, v); check("R6 count holds", v, 0);

        // R7 enable-all through control word 0
        wr(LD0, 20); wr(LD1, 20);
        wr(CTL1, B_LOAD | B_DOWN | B_RELD | B_GEN);
        wr(CTL0, B_LOAD | B_DOWN | B_RELD | B_GEN);
        wr(CTL1, B_DOWN | B_RELD | B_GEN);
        wr(CTL0, B_DOWN | B_RELD | B_GEN | B_ALL);
        mism = 0; hits = 0;
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            if (gen0_out != gen1_out) mism++;
            if (gen0_out) hits++;
        end
        check("R7 pulses aligned", mism, 0);
        check("R7 pulses seen", hits, 5);
        rd(CTL1, v); check("R7 ctl1 run set", v, 32'h2D);

        // R9 sweep of period and duty in both directions
        begin
            int dn_l [6] = '{1, 1, 1, 1, 0, 0};
            int p_l  [6] = '{10, 20, 7, 30, 250, 200};
            int d_l  [6] = '{3, 0, 5, 12, 252, 240};
            for (int c = 0; c < 6; c++) begin
                start_pwm(dn_l[c][0], p_l[c], d_l[c], 32'h0);
                measure(2, hi, per);
                check("R9 period", per, clen(dn_l[c][0], p_l[c]));
                check("R9 high time", hi, clen(dn_l[c][0], d_l[c]));
                measure(2, hi, per);
                check("R9 period repeat", per, clen(dn_l[c][0], p_l[c]));
            end
        end

        // R8 output low when stopped
        wr(CTL1, 0); @(negedge clk);
        count_high(2, 80, hits); check("R8 low when disabled", hits, 0);

        // R8 capture bit or cascade on counter 0 blocks the output
        start_pwm(1'b1, 10, 3, B_CAPT);
        count_high(2, 80, hits); check("R8 capture blocks", hits, 0);
        start_pwm(1'b1, 10, 3, B_CASC);
        count_high(2, 80, hits); check("R8 cascade blocks", hits, 0);

        // R10 duty equal to or longer than period
        start_pwm(1'b1, 5, 5, 32'h0);
        count_high(2, 150, hits); check("R10 equal duty low", hits, 0);
        start_pwm(1'b1, 5, 9, 32'h0);
        count_high(2, 150, hits); check("R10 longer duty low", hits, 0);
        start_pwm(1'b0, 250, 250, 32'h0);
        count_high(2, 150, hits); check("R10 equal duty up", hits, 0);

        // R11 load written mid-run waits for the next reload
        start_pwm(1'b1, 20, 5, 32'h0);
        measure(2, hi, per);
        begin
            int   n = 0;
            int   g = 0;
            logic prev;
            while (!pwm_out && g < 3000) begin @(negedge clk); g++; end
            bus_wr = 1'b1; bus_addr = LD0; bus_wdata = 40;
            prev = 1'b1;
            while (g < 3000) begin
                @(negedge clk); g++; n++;
                bus_wr = 1'b0;
                if (pwm_out && !prev) break;
                prev = pwm_out;
            end
            check("R11 old period completes", n, clen(1'b1, 20));
        end
        measure(2, hi, per);
        check("R11 new period", per, clen(1'b1, 40));
        check("R11 duty kept", hi, clen(1'b1, 5));

        wr(CTL0, 0); wr(CTL1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule